// File: doc/BRIEF.md
# Tapered-Window Bitstream Accumulator

This block turns the one-bit output of a delta-sigma comparator into a multi-bit sample. A measurement period has a fixed number of bitstream samples, set by a parameter. Each sample that is 1 adds the current window weight into a 32-bit accumulator. The weight is not flat over the period. It rises smoothly from zero at the start, stays at a maximum through the long middle section, and falls back to zero at the end. Tapering both ends this way suppresses the artefacts that an abrupt start and stop would leave in the result.

The weight comes from a small up/down counter. Its step size changes from sample to sample and never exceeds the range of a 4-bit signed value. At elaboration the step sequence for each profile is computed from a smooth cubic taper, which is a close fit to a raised cosine. The falling end replays the rising steps in reverse order with the sign flipped, so the weight always ends at exactly zero. A 2-bit select picks one of four profiles, which combine a ramp length of 16 or 24 samples with a peak weight of 32 or 64.

Bitstream samples enter over a valid/ready pair. `bs_ready` is high only while a conversion runs. A sample is consumed on a clock edge where `bs_valid` and `bs_ready` are both high. Holding `bs_valid` low stalls the window without losing its place. `start` and `done` are plain control pins.

Top module: `taper_accum`

## Requirements
- R1: After reset `result` is 0, `done` is 0 and `bs_ready` is 0.
- R2: A `start` pulse while idle clears `result`, captures `prof`, and raises `bs_ready` in the next cycle.
- R3: A sample is consumed only on an edge with `bs_valid` and `bs_ready` both high. A consumed 1 adds the current weight to `result`, and a consumed 0 leaves `result` unchanged.
- R4: Profile encoding: `prof[0]` = 0 gives a peak of 32 and 1 gives 64. `prof[1]` = 0 gives a ramp of 16 samples and 1 gives 24. Every sample from index 32 through PERIOD-33 carries the peak weight.
- R5: Sample i < 32 has weight W(i). W(i) is 0 for the first (32-N)/2 positions, then runs through N ramp values r(k), then holds the peak M. For k < N/2, r(k) = floor((2·M·(3u²d − 2u³) + d³) / (2d³)) with u = 2k+1 and d = 2N, and r(N−1−k) = M − r(k). Mirrored ramp values therefore sum to M.
- R6: Sample PERIOD−1−i has weight W(i), so the falling end mirrors the rising end and the last sample weighs 0.
- R7: `done` pulses high for exactly one cycle, in the cycle after the PERIOD-th sample is consumed. `bs_ready` is low in that cycle.
- R8: `result` holds its final value until the next accepted `start`. Changes on `start` or `prof` during a conversion have no effect.
- R9: Cycles with `bs_valid` low do not advance the window, even when `bs_bit` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a conversion when idle |
| prof | input | 2 | Window profile select |
| bs_valid | input | 1 | Bitstream sample present |
| bs_bit | input | 1 | Bitstream sample value |
| bs_ready | output | 1 | High while a conversion consumes samples |
| result | output | ACC_W | Accumulated windowed sum |
| done | output | 1 | One-cycle end-of-period strobe |

## Verification
On every cycle the assertions check five things: a consumed 0 leaves the sum unchanged, a consumed 1 raises it by exactly the registered weight, and the weight never exceeds the selected peak. They also check that `done` is a single-cycle strobe that never overlaps `bs_ready`, and that the sum holds while idle. Only the bench scenarios can show the shape of the window itself. They do this by comparing complete sums against values computed from the taper formula. Patterns that light only the rising end or only the falling end expose the mirroring and the symmetric-pair sums, and stalls and ignored mid-conversion `start` and `prof` changes cover the flow control.

// File: rtl/taper_pkg.sv
`timescale 1ns/1ps
package taper_pkg;
  typedef logic [1:0] prof_t;

  localparam int PEAK_MAX = 64;
  localparam int WW       = $clog2(PEAK_MAX) + 1;

  function automatic int ramp_len(input int p);
    return p[1] ? 24 : 16;
  endfunction

  function automatic int ramp_peak(input int p);
    return p[0] ? 64 : 32;
  endfunction

  // lower half of the cubic taper, rounded half up
  function automatic int half_val(input int n, input int m, input int k);
    int u, d, num, den;
    u   = 2 * k + 1;
    d   = 2 * n;
    num = m * (3 * u * u * d - 2 * u * u * u);
    den = d * d * d;
    return (2 * num + den) / (2 * den);
  endfunction

  // weight at rising-edge position q of a window with 'steps' positions
  function automatic int pos_val(input int p, input int steps, input int q);
    int n, m, z, k;
    n = ramp_len(p);
    m = ramp_peak(p);
    z = (steps - n) / 2;
    if (q < z)      return 0;
    if (q >= z + n) return m;
    k = q - z;
    if (k < n / 2)  return half_val(n, m, k);
    return m - half_val(n, m, n - 1 - k);
  endfunction
endpackage

// File: rtl/taper_step_rom.sv
`timescale 1ns/1ps
module taper_step_rom #(
  parameter int PERIOD = 4096,
  parameter int STEPS  = 32,
  parameter int INC_W  = 4,
  parameter int IW     = $clog2(PERIOD) + 1
) (
  input  logic [1:0]             prof,
  input  logic [IW-1:0]          idx,
  output logic signed [INC_W-1:0] inc
);
  import taper_pkg::*;

  localparam int TABW = 4 * STEPS * INC_W;

  function automatic logic [TABW-1:0] build_tab();
    logic [TABW-1:0] t;
    int d;
    t = '0;
    for (int p = 0; p < 4; p++) begin
      for (int q = 0; q < STEPS; q++) begin
        d = pos_val(p, STEPS, q) - ((q == 0) ? 0 : pos_val(p, STEPS, q - 1));
        t[(p * STEPS + q) * INC_W +: INC_W] = INC_W'(d);
      end
    end
    return t;
  endfunction

  localparam logic [TABW-1:0] TAB = build_tab();

  always_comb begin
    int i;
    int pi;
    i  = int'(idx);
    pi = int'(prof);
    inc = '0;
    if (i < STEPS)
      inc = TAB[(pi * STEPS + i) * INC_W +: INC_W];
    else if (i > PERIOD - STEPS && i < PERIOD)
      inc = -$signed(TAB[(pi * STEPS + (PERIOD - i)) * INC_W +: INC_W]);
  end
endmodule

// File: rtl/taper_weight_gen.sv
`timescale 1ns/1ps
module taper_weight_gen #(
  parameter int INC_W = 4,
  parameter int WW    = 7
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic                    step,
  input  logic signed [INC_W-1:0] inc_in,
  output logic [WW-1:0]           weight
);
  logic signed [INC_W-1:0] inc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      weight <= '0;
      inc_q  <= '0;
    end else if (load) begin
      weight <= '0;
      inc_q  <= inc_in;
    end else if (step) begin
      weight <= weight + {{(WW-INC_W){inc_q[INC_W-1]}}, inc_q};
      inc_q  <= inc_in;
    end
  end
endmodule

// File: rtl/taper_sequencer.sv
`timescale 1ns/1ps
module taper_sequencer #(
  parameter int PERIOD = 4096,
  parameter int IW     = $clog2(PERIOD) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    prof,
  input  logic          accept,
  output logic          busy,
  output logic          launch,
  output logic          done,
  output logic [IW-1:0] idx,
  output logic [1:0]    prof_q
);
  assign launch = start && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      idx    <= '0;
      prof_q <= '0;
    end else begin
      done <= 1'b0;
      if (launch) begin
        busy   <= 1'b1;
        idx    <= '0;
        prof_q <= prof;
      end else if (accept) begin
        idx <= idx + IW'(1);
        if (idx == IW'(PERIOD - 1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/taper_accum.sv
`timescale 1ns/1ps
module taper_accum #(
  parameter int PERIOD = 4096,
  parameter int ACC_W  = 32,
  parameter int STEPS  = 32,
  parameter int INC_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       prof,
  input  logic             bs_valid,
  input  logic             bs_bit,
  output logic             bs_ready,
  output logic [ACC_W-1:0] result,
  output logic             done
);
  import taper_pkg::*;

  localparam int IW = $clog2(PERIOD) + 1;

  logic             busy, launch, accept;
  logic [IW-1:0]    idx, idx_sel;
  logic [1:0]       prof_q, prof_sel;
  logic signed [INC_W-1:0] inc_next;
  logic [WW-1:0]    w_q;
  logic [ACC_W-1:0] acc_q;

  assign bs_ready = busy;
  assign accept   = bs_valid && busy;
  assign result   = acc_q;
  assign prof_sel = busy ? prof_q : prof;
  assign idx_sel  = busy ? idx + IW'(2) : IW'(1);

  taper_sequencer #(.PERIOD(PERIOD), .IW(IW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .prof(prof), .accept(accept),
    .busy(busy), .launch(launch), .done(done), .idx(idx), .prof_q(prof_q)
  );

  taper_step_rom #(.PERIOD(PERIOD), .STEPS(STEPS), .INC_W(INC_W), .IW(IW)) u_rom (
    .prof(prof_sel), .idx(idx_sel), .inc(inc_next)
  );

  taper_weight_gen #(.INC_W(INC_W), .WW(WW)) u_wgen (
    .clk(clk), .rst_n(rst_n), .load(launch), .step(accept),
    .inc_in(inc_next), .weight(w_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      acc_q <= '0;
    else if (launch)
      acc_q <= '0;
    else if (accept && bs_bit)
      acc_q <= acc_q + ACC_W'(w_q);
  end
endmodule

// File: rtl/taper_accum_chk.sv
`timescale 1ns/1ps
module taper_accum_chk #(
  parameter int ACC_W = 32,
  parameter int WW    = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             bs_valid,
  input logic             bs_bit,
  input logic             bs_ready,
  input logic             done,
  input logic [ACC_W-1:0] result,
  input logic [WW-1:0]    weight,
  input logic [1:0]       prof_q
);
  a_r3_zero_no_add: assert property (@(posedge clk) disable iff (!rst_n)
    bs_valid && bs_ready && !bs_bit |=> $stable(result));

  a_r3_one_adds_weight: assert property (@(posedge clk) disable iff (!rst_n)
    bs_valid && bs_ready && bs_bit |=>
      (result - $past(result)) == ACC_W'($past(weight)));

  a_r4_weight_cap: assert property (@(posedge clk) disable iff (!rst_n)
    bs_ready |-> int'(weight) <= (prof_q[0] ? 64 : 32));

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r7_done_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !bs_ready);

  a_r2_ready_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    start && !bs_ready |=> bs_ready);

  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bs_ready && !start |=> $stable(result));
endmodule

bind taper_accum taper_accum_chk #(.ACC_W(ACC_W), .WW(taper_pkg::WW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .bs_valid(bs_valid), .bs_bit(bs_bit),
  .bs_ready(bs_ready), .done(done), .result(result), .weight(w_q), .prof_q(prof_q)
);

// File: tb/taper_accum_test.sv
`timescale 1ns/1ps
module taper_accum_test;
  localparam int P = 256;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  prof = 2'd0;
  logic        bs_valid = 1'b0;
  logic        bs_bit = 1'b0;
  logic        bs_ready;
  logic [31:0] result;
  logic        done;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  taper_accum #(.PERIOD(P)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .prof(prof), .bs_valid(bs_valid),
    .bs_bit(bs_bit), .bs_ready(bs_ready), .result(result), .done(done)
  );

  // {gap, pattern[2:0], prof[1:0]}
  localparam logic [5:0] VEC [0:8] = '{
    6'b0_000_00, 6'b0_000_01, 6'b0_000_10, 6'b0_000_11, 6'b1_011_11,
    6'b0_100_10, 6'b1_010_01, 6'b0_101_00, 6'b0_001_11
  };

  function automatic int exp_half(int n, int m, int k);
    int u, d;
    u = 2 * k + 1;
    d = 2 * n;
    return (2 * m * (3 * u * u * d - 2 * u * u * u) + d * d * d) / (2 * d * d * d);
  endfunction

  function automatic int exp_w(int p, int i);
    int n, m, z, q, k;
    n = p[1] ? 24 : 16;
    m = p[0] ? 64 : 32;
    q = (i < 32) ? i : ((i >= P - 32) ? P - 1 - i : 32);
    if (q >= 32) return m;
    z = (32 - n) / 2;
    if (q < z) return 0;
    if (q >= z + n) return m;
    k = q - z;
    return (k < n / 2) ? exp_half(n, m, k) : m - exp_half(n, m, n - 1 - k);
  endfunction

  function automatic logic pat_bit(int pat, int i);
    case (pat)
      0: return 1'b1;
      1: return 1'b0;
      2: return i[0];
      3: return i < 32;
      4: return i >= P - 32;
      default: return ((i * 5) % 7) < 3;
    endcase
  endfunction

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
  endtask

  task automatic kick(logic [1:0] p);
    @(negedge clk);
    prof  = p;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // run one whole period, return at the negedge after the last accept
  task automatic run(int p, int pat, bit gap, output longint expv);
    expv = 0;
    kick(2'(p));
    for (int i = 0; i < P; i++) begin
      if (gap && (i % 3 == 0)) begin
        bs_valid = 1'b0;
        bs_bit   = 1'b1;            // R9: must not be counted
        @(negedge clk);
      end
      if (gap && i == P / 2) begin
        start = 1'b1;               // R8: ignored mid-conversion
        prof  = ~prof;
      end else begin
        start = 1'b0;
      end
      bs_valid = 1'b1;
      bs_bit   = pat_bit(pat, i);
      if (pat_bit(pat, i)) expv += exp_w(p, i);
      @(negedge clk);
    end
    bs_valid = 1'b0;
    bs_bit   = 1'b0;
    start    = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    longint e;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 result", result, 0);
    check("R1 done", done, 0);
    check("R1 ready", bs_ready, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready idle", bs_ready, 0);

    // R2 ready follows start
    kick(2'd3);
    check("R2 ready", bs_ready, 1);
    check("R2 cleared", result, 0);
    for (int i = 0; i < P; i++) begin
      bs_valid = 1'b1;
      bs_bit   = 1'b1;
      @(negedge clk);
    end
    bs_valid = 1'b0;
    check("R4 all-ones 24/64", result, 14336);

    // vector table: R3 R5 R6 R7 R8 R9
    foreach (VEC[v]) begin
      run(int'(VEC[v][1:0]), int'(VEC[v][4:2]), VEC[v][5], e);
      check("R7 done", done, 1);
      check("R7 ready low", bs_ready, 0);
      check("R3 R5 R6 result", result, e);
      @(negedge clk);
      check("R7 done drops", done, 0);
    end

    // R8 hold while idle, R5 symmetric pairs, R6 falling end
    run(0, 3, 1'b0, e);
    check("R5 rising 16/32", result, 512);
    repeat (5) @(negedge clk);
    check("R8 held", result, 512);
    run(3, 4, 1'b0, e);
    check("R6 falling 24/64", result, 1024);
    run(0, 0, 1'b0, e);
    check("R4 all-ones 16/32", result, 7168);

    summary();
    $finish;
  end
endmodule